// File: doc/BRIEF.md
# SHA-2 Two-Round Compression Datapath

This unit advances a SHA-2 working state by two rounds for one group of four vector elements. The eight working variables arrive split across two 4-element operands: one carries a, b, e, f and the other carries c, d, g, h. A third 4-element operand carries schedule words that already have the round constants added. The unit returns the new a, b, e, f group. The caller writes that group back over the destination, which is the operand that held c, d, g, h. One datapath serves both SHA-256, with 32-bit elements, and SHA-512, with 64-bit elements.

A variant input chooses which pair of schedule elements drives the two rounds. Issuing the low variant and then the high variant advances the state by four rounds. An element-width input selects the word size, and any width other than 32 or 64 raises an error flag instead of producing a result.

Transactions use a valid/ready handshake and move one element group each. The result is held in a register until the consumer accepts it.

Top module: `sha2_two_round_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An input accepted on a clock edge (`in_valid && in_ready`) makes `out_valid` 1 after that edge. `out_valid` falls after an edge where `out_ready` is 1 and no new input is accepted.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_group` and `out_err` stay unchanged.
- R4: `in_sew` is 32 for 32-bit elements and 64 for 64-bit elements. Any other value gives a result with `out_err` = 1 and `out_group` = 0. A legal value gives `out_err` = 0.
- R5: Element k of every 256-bit bus occupies bits [64k+63:64k]. With 32-bit elements, only the low 32 bits of each lane are used, the upper input bits are ignored, and the upper 32 bits of each output lane are 0.
- R6: `in_abef` lanes 0..3 hold a, b, e, f. `in_cdgh` lanes 0..3 hold c, d, g, h.
- R7: With `in_high` = 0, schedule lane 0 feeds the first round and lane 1 feeds the second. With `in_high` = 1, lanes 2 and 3 feed them instead.
- R8: With 32-bit elements, each round computes T1 = h + Σ1(e) + Ch(e,f,g) + W and T2 = Σ0(a) + Maj(a,b,c) modulo 2^32. Σ0 rotates right by 2, 13 and 22; Σ1 rotates right by 6, 11 and 25. The state then shifts: h←g, g←f, f←e, e←d+T1, d←c, c←b, b←a, a←T1+T2.
- R9: With 64-bit elements, the same rounds are computed modulo 2^64. Σ0 rotates right by 28, 34 and 39; Σ1 rotates right by 14, 18 and 41.
- R10: `out_group` lanes 0..3 carry the new a, b, e, f after the second round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input group is offered |
| in_ready | output | 1 | Unit can take an input group |
| in_sew | input | 7 | Element width in bits (32 or 64) |
| in_high | input | 1 | 0: schedule lanes 0,1; 1: lanes 2,3 |
| in_abef | input | 256 | State operand a,b,e,f |
| in_cdgh | input | 256 | State operand c,d,g,h |
| in_sched | input | 256 | Schedule words plus round constants |
| out_valid | output | 1 | Result is held on the outputs |
| out_ready | input | 1 | Consumer takes the result |
| out_err | output | 1 | Element width was illegal |
| out_group | output | 256 | New a,b,e,f group |

## Verification
The assertions assume that the consumer obeys the handshake, so a result that is not taken keeps `out_ready` low rather than dropping the transaction. They also assume that the inputs are only meaningful on an edge where an input is accepted. The stimulus offers each group until it is taken and randomizes `out_ready` so that stalls of several cycles occur. Garbage is placed in the upper half of each lane in 32-bit mode, and width codes such as 0, 16, 48 and 96 exercise the error path while staying inside the 7-bit field.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;
  localparam int LANE_W  = 64;
  localparam int NARROW  = 32;
  localparam int LANES   = 4;
  localparam int GROUP_W = LANE_W * LANES;
  localparam int ROUNDS  = 2;

  typedef logic [LANE_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } state_t;

  function automatic word_t width_mask(input logic wide);
    return wide ? {LANE_W{1'b1}} : {{(LANE_W-NARROW){1'b0}}, {NARROW{1'b1}}};
  endfunction

  function automatic word_t rot_right(input word_t x, input int n, input logic wide);
    logic [NARROW-1:0] lo;
    lo = x[NARROW-1:0];
    if (wide) return (x >> n) | (x << (LANE_W - n));
    return {{(LANE_W-NARROW){1'b0}}, (lo >> n) | (lo << (NARROW - n))};
  endfunction

  function automatic word_t big_sigma0(input word_t x, input logic wide);
    if (wide) return rot_right(x, 28, 1'b1) ^ rot_right(x, 34, 1'b1) ^ rot_right(x, 39, 1'b1);
    return rot_right(x, 2, 1'b0) ^ rot_right(x, 13, 1'b0) ^ rot_right(x, 22, 1'b0);
  endfunction

  function automatic word_t big_sigma1(input word_t x, input logic wide);
    if (wide) return rot_right(x, 14, 1'b1) ^ rot_right(x, 18, 1'b1) ^ rot_right(x, 41, 1'b1);
    return rot_right(x, 6, 1'b0) ^ rot_right(x, 11, 1'b0) ^ rot_right(x, 25, 1'b0);
  endfunction
endpackage

// File: rtl/sha2r_round.sv
module sha2r_round
  import sha2r_pkg::*;
(
  input  logic   wide,
  input  state_t st_i,
  input  word_t  w_i,
  output state_t st_o
);
  word_t msk;
  word_t choose;
  word_t major;
  word_t t1;
  word_t t2;

  always_comb begin
    msk    = width_mask(wide);
    choose = (st_i.e & st_i.f) ^ (~st_i.e & st_i.g);
    major  = (st_i.a & st_i.b) ^ (st_i.a & st_i.c) ^ (st_i.b & st_i.c);
    t1     = (st_i.h + big_sigma1(st_i.e, wide) + choose + w_i) & msk;
    t2     = (big_sigma0(st_i.a, wide) + major) & msk;
    st_o.h = st_i.g;
    st_o.g = st_i.f;
    st_o.f = st_i.e;
    st_o.e = (st_i.d + t1) & msk;
    st_o.d = st_i.c;
    st_o.c = st_i.b;
    st_o.b = st_i.a;
    st_o.a = (t1 + t2) & msk;
  end
endmodule

// File: rtl/sha2r_rounds.sv
module sha2r_rounds
  import sha2r_pkg::*;
#(
  parameter int N_ROUNDS = ROUNDS
) (
  input  logic                  wide,
  input  state_t                st_i,
  input  word_t [N_ROUNDS-1:0]  w_i,
  output state_t                st_o
);
  state_t stage [N_ROUNDS+1];

  assign stage[0] = st_i;

  for (genvar r = 0; r < N_ROUNDS; r++) begin : g_round
    sha2r_round u_round (
      .wide (wide),
      .st_i (stage[r]),
      .w_i  (w_i[r]),
      .st_o (stage[r+1])
    );
  end

  assign st_o = stage[N_ROUNDS];
endmodule

// File: rtl/sha2_two_round_unit.sv
module sha2_two_round_unit
  import sha2r_pkg::*;
#(
  parameter int SEW_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SEW_W-1:0]   in_sew,
  input  logic               in_high,
  input  logic [GROUP_W-1:0] in_abef,
  input  logic [GROUP_W-1:0] in_cdgh,
  input  logic [GROUP_W-1:0] in_sched,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_err,
  output logic [GROUP_W-1:0] out_group
);
  localparam int SEL_BASE = LANES / 2;

  logic   accept;
  logic   wide;
  logic   sew_ok;
  word_t  msk;
  word_t  abef_w  [LANES];
  word_t  cdgh_w  [LANES];
  word_t  sched_w [LANES];
  word_t [ROUNDS-1:0] w_sel;
  state_t st_in;
  state_t st_out;
  logic [GROUP_W-1:0] res_group;

  logic               valid_d, valid_q;
  logic               err_d,   err_q;
  logic [GROUP_W-1:0] grp_d,   grp_q;

  always_comb begin
    wide   = (in_sew == SEW_W'(LANE_W));
    sew_ok = wide || (in_sew == SEW_W'(NARROW));
    msk    = width_mask(wide);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign abef_w[k]  = in_abef[k*LANE_W +: LANE_W]  & msk;
    assign cdgh_w[k]  = in_cdgh[k*LANE_W +: LANE_W]  & msk;
    assign sched_w[k] = in_sched[k*LANE_W +: LANE_W] & msk;
  end

  for (genvar r = 0; r < ROUNDS; r++) begin : g_wsel
    assign w_sel[r] = in_high ? sched_w[SEL_BASE + r] : sched_w[r];
  end

  always_comb begin
    st_in.a = abef_w[0];
    st_in.b = abef_w[1];
    st_in.e = abef_w[2];
    st_in.f = abef_w[3];
    st_in.c = cdgh_w[0];
    st_in.d = cdgh_w[1];
    st_in.g = cdgh_w[2];
    st_in.h = cdgh_w[3];
  end

  sha2r_rounds #(.N_ROUNDS(ROUNDS)) u_rounds (
    .wide (wide),
    .st_i (st_in),
    .w_i  (w_sel),
    .st_o (st_out)
  );

  always_comb begin
    res_group = {st_out.f, st_out.e, st_out.b, st_out.a};
    if (!sew_ok) res_group = '0;
  end

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    err_d   = err_q;
    grp_d   = grp_q;
    if (accept) begin
      valid_d = 1'b1;
      err_d   = !sew_ok;
      grp_d   = res_group;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      grp_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (accept) begin
        err_q <= err_d;
        grp_q <= grp_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_group = grp_q;
endmodule

// File: rtl/sha2r_checker.sv
module sha2r_checker #(
  parameter int SEW_W   = 7,
  parameter int GROUP_W = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [SEW_W-1:0]   in_sew,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_err,
  input logic [GROUP_W-1:0] out_group
);
  logic acc;
  logic narrow_q;
  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) narrow_q <= 1'b0;
    else if (acc) narrow_q <= (in_sew == SEW_W'(32));
  end

  p_reset_ready_r1: assert property (@(posedge clk) !rst_n |-> in_ready && !out_valid);

  p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_ready_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_group) && $stable(out_err));

  p_bad_sew_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_sew != SEW_W'(32) && in_sew != SEW_W'(64) |=> out_err);

  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_group == '0);

  p_narrow_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && narrow_q |-> out_group[63:32] == '0 && out_group[127:96] == '0
                             && out_group[191:160] == '0 && out_group[255:224] == '0);
endmodule

bind sha2_two_round_unit sha2r_checker #(.SEW_W(SEW_W), .GROUP_W(sha2r_pkg::GROUP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sew    (in_sew),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_err   (out_err),
  .out_group (out_group)
);

// File: tb/sim_sha2_two_round_unit.sv
`timescale 1ns/1ps
module sim_sha2_two_round_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [6:0]   in_sew = 7'd32;
  logic         in_high = 1'b0;
  logic [255:0] in_abef = '0;
  logic [255:0] in_cdgh = '0;
  logic [255:0] in_sched = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_err;
  logic [255:0] out_group;

  int errors = 0;
  int checks = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [255:0] exp_grp_q [$];
  logic         exp_err_q [$];
  string        exp_tag_q [$];

  always #4 clk = ~clk;

  sha2_two_round_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sew(in_sew), .in_high(in_high), .in_abef(in_abef), .in_cdgh(in_cdgh),
    .in_sched(in_sched), .out_valid(out_valid), .out_ready(out_ready),
    .out_err(out_err), .out_group(out_group)
  );

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_rot(input logic [63:0] x, input int n, input bit wide);
    logic [31:0] y;
    y = x[31:0];
    if (wide) return (x >> n) | (x << (64 - n));
    return {32'h0, (y >> n) | (y << (32 - n))};
  endfunction

  function automatic logic [255:0] model(input logic [255:0] abef, input logic [255:0] cdgh,
                                         input logic [255:0] sch, input bit wide, input bit high);
    logic [63:0] mk, a, b, c, d, e, f, g, h, t1, t2, s0, s1, w;
    mk = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    a = abef[63:0] & mk;    b = abef[127:64] & mk;
    e = abef[191:128] & mk; f = abef[255:192] & mk;
    c = cdgh[63:0] & mk;    d = cdgh[127:64] & mk;
    g = cdgh[191:128] & mk; h = cdgh[255:192] & mk;
    for (int r = 0; r < 2; r++) begin
      w = sch[((high ? 2 : 0) + r)*64 +: 64] & mk;
      if (wide) begin
        s1 = m_rot(e,14,1) ^ m_rot(e,18,1) ^ m_rot(e,41,1);
        s0 = m_rot(a,28,1) ^ m_rot(a,34,1) ^ m_rot(a,39,1);
      end else begin
        s1 = m_rot(e,6,0) ^ m_rot(e,11,0) ^ m_rot(e,25,0);
        s0 = m_rot(a,2,0) ^ m_rot(a,13,0) ^ m_rot(a,22,0);
      end
      t1 = (h + s1 + ((e & f) ^ (~e & g)) + w) & mk;
      t2 = (s0 + ((a & b) ^ (a & c) ^ (b & c))) & mk;
      h = g; g = f; f = e; e = (d + t1) & mk;
      d = c; c = b; b = a; a = (t1 + t2) & mk;
    end
    return {f, e, b, a};
  endfunction

  task automatic send(input string tag, input logic [255:0] abef, input logic [255:0] cdgh,
                      input logic [255:0] sch, input logic [6:0] sew, input bit high,
                      input bit use_exp, input logic [255:0] exp_in);
    bit ok;
    bit legal;
    legal = (sew == 7'd32) || (sew == 7'd64);
    in_valid = 1'b1; in_abef = abef; in_cdgh = cdgh; in_sched = sch;
    in_sew = sew; in_high = high;
    exp_tag_q.push_back(tag);
    exp_err_q.push_back(!legal);
    if (!legal) exp_grp_q.push_back('0);
    else if (use_exp) exp_grp_q.push_back(exp_in);
    else exp_grp_q.push_back(model(abef, cdgh, sch, sew == 7'd64, high));
    do begin
      #1 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  initial begin : ready_gen
    forever begin
      @(negedge clk);
      out_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  initial begin : monitor
    logic [255:0] held;
    logic         held_err;
    bit           holding;
    holding = 1'b0;
    held = '0;
    held_err = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (holding) begin
          check("R3 hold valid", {255'b0, out_valid}, 256'd1);
          check("R3 hold group", out_group, held);
          check("R3 hold err", {255'b0, out_err}, {255'b0, held_err});
        end
        holding = 1'b0;
        check("R2 in_ready rule", {255'b0, in_ready}, {255'b0, !out_valid || out_ready});
        if (out_valid && out_ready) begin
          if (exp_grp_q.size() == 0) begin
            errors++; checks++;
            $display("FAIL R2 unexpected result actual=%h expected=none", out_group);
          end else begin
            string t;
            t = exp_tag_q.pop_front();
            check({t, " group"}, out_group, exp_grp_q.pop_front());
            check({t, " err (R4)"}, {255'b0, out_err}, {255'b0, exp_err_q.pop_front()});
          end
        end else if (out_valid) begin
          holding = 1'b1;
          held = out_group;
          held_err = out_err;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    logic [255:0] kat_abef, kat_cdgh, kat_exp;
    kat_abef = {64'h9b05688c, 64'h510e527f, 64'hbb67ae85, 64'h6a09e667};
    kat_cdgh = {64'h5be0cd19, 64'h1f83d9ab, 64'ha54ff53a, 64'h3c6ef372};
    kat_exp  = {64'hfa2a4622, 64'h78ce7989, 64'h5d6aebcd, 64'h5a6ad9ad};

    repeat (3) @(negedge clk);
    check("R1 reset in_ready", {255'b0, in_ready}, 256'd1);
    check("R1 reset out_valid", {255'b0, out_valid}, 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 after release in_ready", {255'b0, in_ready}, 256'd1);
    check("R1 after release out_valid", {255'b0, out_valid}, 256'd0);
    @(negedge clk);

    // Known answer, R6 R7 R8 R10: low lanes 0,1
    send("R8 R10 kat low", kat_abef, kat_cdgh,
         {64'h0, 64'h0, 64'h71374491, 64'ha3ec9318}, 7'd32, 1'b0, 1'b1, kat_exp);
    // Same words in lanes 2,3 with junk in 0,1 (R7)
    send("R7 kat high", kat_abef, kat_cdgh,
         {64'h71374491, 64'ha3ec9318, 64'h12345678, 64'hdeadbeef}, 7'd32, 1'b1, 1'b1, kat_exp);
    // Garbage in upper lane halves must be ignored (R5)
    send("R5 upper ignored", kat_abef | {4{64'hA5A5_0000_0000_0000}},
         kat_cdgh | {4{64'h0F0F_F0F0_0000_0000}},
         {64'h0, 64'h0, 64'hFFFF_0000_71374491, 64'h1111_2222_a3ec9318}, 7'd32, 1'b0, 1'b1, kat_exp);
    // Illegal widths (R4)
    send("R4 sew0", kat_abef, kat_cdgh, '1, 7'd0, 1'b0, 1'b0, '0);
    send("R4 sew16", kat_abef, kat_cdgh, '1, 7'd16, 1'b1, 1'b0, '0);
    send("R4 sew48", kat_abef, kat_cdgh, '1, 7'd48, 1'b0, 1'b0, '0);
    send("R4 sew96", kat_abef, kat_cdgh, '1, 7'd96, 1'b0, 1'b0, '0);

    stall_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [255:0] x, y, z;
      for (int k = 0; k < 8; k++) begin
        x[k*32 +: 32] = $urandom;
        y[k*32 +: 32] = $urandom;
        z[k*32 +: 32] = $urandom;
      end
      if (i % 4 == 0) send("R8 R7 narrow low", x, y, z, 7'd32, 1'b0, 1'b0, '0);
      else if (i % 4 == 1) send("R8 R7 narrow high", x, y, z, 7'd32, 1'b1, 1'b0, '0);
      else if (i % 4 == 2) send("R9 R10 wide low", x, y, z, 7'd64, 1'b0, 1'b0, '0);
      else send("R9 R6 wide high", x, y, z, 7'd64, 1'b1, 1'b0, '0);
      if (i % 7 == 3) send("R4 sew33", x, y, z, 7'd33, 1'b0, 1'b0, '0);
    end

    stall_en = 1'b0;
    repeat (20) @(negedge clk);
    check("R2 all results drained", {224'b0, 32'(exp_grp_q.size())}, 256'd0);
    check("R2 idle out_valid", {255'b0, out_valid}, 256'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule